// File: doc/BRIEF.md
# Performance-State Frequency Table Discovery Sequencer

This block runs the bring-up flow of a frequency-scaling controller that delegates the actual clock and voltage changes to a management co-processor. It does not change any clock itself. It talks to a separate command issuer through a request/acknowledge port and reads two status words from the shared mailbox through a simple read port.

After a start pulse, the sequencer first checks that compatible firmware is present. It records the performance state that is active at that point. It then steps the co-processor through every performance state in ascending order and samples the frequency word after each step, scaling it from MHz to kHz. When the scan is complete it puts the original state back, sends the enable command, and reads the state again. It reports that state's index and frequency next to the discovered table.

The published table is double-buffered. Entries collect in a scratch copy and are published in one step only when the whole flow succeeds. While a run is in progress, and after a failed run, the outputs keep their previous values and are flagged as not valid.

Top module: `pstate_discovery`

## Requirements
- R1: After a synchronous reset the following outputs are low or zero: `tbl_valid`, `done`, `err`, `fw_ok`, `cmd_req`, `mb_rd`, `cur_khz` and every table entry.
- R2: Firmware counts as present only when both conditions hold: the get-map command (code 0x30, receive direction) returns a status other than 0xF1 and other than 0xF2, and the mailbox word at offset 0x34 equals 0xA11600D1. If firmware is absent, `done` and `err` rise, `fw_ok` stays low, and no further command is sent.
- R3: Once presence is confirmed, the state fetch command (code 0x40, `cmd_send`=0) is sent. Its returned argument word 0 is saved as the state to restore.
- R4: The scan sends set-state (code 0x41, `cmd_send`=1) with argument word 0 equal to 0, 1, 2, 3 and then 4. Each successful set-state is followed by exactly one mailbox read at offset 0x50.
- R5: Each table entry i holds the word read after state i multiplied by 1000. A product above 0xFFFFFFFF is stored as 0xFFFFFFFF. Entry i occupies `tbl_khz[32*i+31:32*i]`.
- R6: After the fifth entry, a further set-state command restores the saved state.
- R7: After the restore, the enable command (code 0x11, `cmd_send`=0, argument 0) is sent, followed by a state fetch (0x40). On success, `cur_state` takes that fetch's argument word 0, `cur_khz` takes the matching table entry, and `tbl_valid`, `fw_ok` and `done` are all high.
- R8: Any command other than get-map whose status is not 0xF0 (success) aborts the run. `done` and `err` rise, `tbl_valid` stays low, and the table keeps its previous contents.
- R9: If the final state fetch returns an index above 4, the run ends with `err` high and `tbl_valid` low.
- R10: A start pulse while idle re-runs the whole flow. From the cycle after start until the run completes, `tbl_valid` is low and `tbl_khz` does not change.
- R11: A command request stays asserted, with constant code, direction and argument, until it is acknowledged. Each mailbox read is a one-cycle pulse, and its data is sampled on the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts (or re-runs) the sequence when idle |
| cmd_req | output | 1 | Command request to the issuer |
| cmd_code | output | 8 | Command code |
| cmd_send | output | 1 | 1 = arguments are sent, 0 = arguments are returned |
| cmd_arg0 | output | 32 | Argument word 0 sent with the command |
| cmd_ack | input | 1 | One-cycle completion from the issuer |
| cmd_status | input | 8 | Completion status (0xF0 = success) |
| cmd_rarg0 | input | 32 | Returned argument word 0 |
| mb_rd | output | 1 | Mailbox read strobe |
| mb_addr | output | 8 | Mailbox byte offset |
| mb_rdata | input | 32 | Mailbox read data, valid the cycle after `mb_rd` |
| tbl_khz | output | 160 | Five frequency entries in kHz, entry 0 in the low bits |
| tbl_valid | output | 1 | Table and current-state outputs are valid |
| cur_state | output | 3 | Current performance state index |
| cur_khz | output | 32 | Frequency of the current state in kHz |
| fw_ok | output | 1 | Compatible firmware detected |
| done | output | 1 | Last run finished (success or failure) |
| err | output | 1 | Last run failed |

## Verification
The properties assume that the issuer pulses `cmd_ack` for a single cycle and only while a request is open. They also assume that `start` arrives only while the block is idle. The bench's issuer model starts a countdown of one to four cycles when it sees a new request and then drives exactly one acknowledge. The bench raises `start` only after `done` has been observed, so the stimulus stays inside these assumptions. Returned status values, frequency words, the initial state, the saturation threshold and the injected faults are drawn from a seeded `$urandom` stream or placed directly, all within the handshake rules above.

// File: rtl/pstate_disc_pkg.sv
package pstate_disc_pkg;
  localparam logic [7:0] OP_GET_MAP   = 8'h30;
  localparam logic [7:0] OP_GET_STATE = 8'h40;
  localparam logic [7:0] OP_SET_STATE = 8'h41;
  localparam logic [7:0] OP_ENABLE    = 8'h11;

  localparam logic [7:0] ST_OK        = 8'hF0;
  localparam logic [7:0] ST_BAD_CMD   = 8'hF1;
  localparam logic [7:0] ST_NO_SUPP   = 8'hF2;

  typedef enum logic [3:0] {
    S_IDLE, S_MAP, S_MAGIC, S_GET0, S_SET, S_FRQ, S_RESTORE, S_ENABLE, S_GET1
  } seq_state_t;
endpackage

// File: rtl/khz_scale.sv
module khz_scale #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] mhz,
  output logic [DW-1:0] khz
);
  localparam int PW = DW + 10;
  logic [PW-1:0] ext, prod;

  always_comb begin
    ext  = PW'(mhz);
    // 1000 = 1024 - 16 - 8
    prod = (ext << 10) - (ext << 4) - (ext << 3);
    khz  = (|prod[PW-1:DW]) ? {DW{1'b1}} : prod[DW-1:0];
  end
endmodule

// File: rtl/freq_table.sv
module freq_table #(
  parameter int N  = 5,
  parameter int DW = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            commit,
  input  logic [IW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic [N*DW-1:0] pub
);
  logic [DW-1:0] scratch [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IW'(g)) scratch[g] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (rst)         pub[g*DW +: DW] <= '0;
      else if (commit) pub[g*DW +: DW] <= scratch[g];
    end
  end

  assign rd_data = scratch[rd_idx];
endmodule

// File: rtl/pstate_discovery.sv
module pstate_discovery
  import pstate_disc_pkg::*;
#(
  parameter int              NUM_STATES = 5,
  parameter int              DW         = 32,
  parameter int              AW         = 8,
  parameter logic [AW-1:0]   MAGIC_OFS  = 8'h34,
  parameter logic [AW-1:0]   FREQ_OFS   = 8'h50,
  parameter logic [DW-1:0]   FW_MAGIC   = 32'hA11600D1,
  localparam int             IW = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  output logic                   cmd_req,
  output logic [7:0]             cmd_code,
  output logic                   cmd_send,
  output logic [DW-1:0]          cmd_arg0,
  input  logic                   cmd_ack,
  input  logic [7:0]             cmd_status,
  input  logic [DW-1:0]          cmd_rarg0,
  output logic                   mb_rd,
  output logic [AW-1:0]          mb_addr,
  input  logic [DW-1:0]          mb_rdata,
  output logic [NUM_STATES*DW-1:0] tbl_khz,
  output logic                   tbl_valid,
  output logic [IW-1:0]          cur_state,
  output logic [DW-1:0]          cur_khz,
  output logic                   fw_ok,
  output logic                   done,
  output logic                   err
);
  localparam logic [IW-1:0] LAST = IW'(NUM_STATES - 1);

  seq_state_t    st;
  logic [IW-1:0] idx;
  logic [DW-1:0] saved;
  logic          map_bad;
  logic [DW-1:0] scaled, rd_khz;
  logic          commit, ok_rsp, idx_ok;

  assign ok_rsp = cmd_ack && (cmd_status == ST_OK);
  assign idx_ok = (cmd_rarg0 <= DW'(NUM_STATES - 1));
  assign commit = (st == S_GET1) && ok_rsp && idx_ok;

  khz_scale #(.DW(DW)) u_scale (.mhz(mb_rdata), .khz(scaled));

  freq_table #(.N(NUM_STATES), .DW(DW)) u_tbl (
    .clk(clk), .rst(rst),
    .wr_en(st == S_FRQ), .wr_idx(idx), .wr_data(scaled),
    .commit(commit), .rd_idx(cmd_rarg0[IW-1:0]), .rd_data(rd_khz),
    .pub(tbl_khz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; idx <= '0; saved <= '0; map_bad <= 1'b0;
      cmd_req <= 1'b0; cmd_code <= '0; cmd_send <= 1'b0; cmd_arg0 <= '0;
      mb_rd <= 1'b0; mb_addr <= '0;
      tbl_valid <= 1'b0; cur_state <= '0; cur_khz <= '0;
      fw_ok <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      mb_rd <= 1'b0;
      if (cmd_ack) cmd_req <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tbl_valid <= 1'b0; fw_ok <= 1'b0; done <= 1'b0; err <= 1'b0;
          cmd_req <= 1'b1; cmd_code <= OP_GET_MAP; cmd_send <= 1'b0; cmd_arg0 <= '0;
          st <= S_MAP;
        end
        S_MAP: if (cmd_ack) begin
          map_bad <= (cmd_status == ST_BAD_CMD) || (cmd_status == ST_NO_SUPP);
          mb_rd <= 1'b1; mb_addr <= MAGIC_OFS;
          st <= S_MAGIC;
        end
        S_MAGIC: begin
          if (mb_rdata == FW_MAGIC && !map_bad) begin
            fw_ok <= 1'b1;
            cmd_req <= 1'b1; cmd_code <= OP_GET_STATE; cmd_send <= 1'b0; cmd_arg0 <= '0;
            st <= S_GET0;
          end else begin
            done <= 1'b1; err <= 1'b1; st <= S_IDLE;
          end
        end
        S_GET0: if (cmd_ack) begin
          if (!ok_rsp) begin done <= 1'b1; err <= 1'b1; st <= S_IDLE; end
          else begin
            saved <= cmd_rarg0; idx <= '0;
            cmd_req <= 1'b1; cmd_code <= OP_SET_STATE; cmd_send <= 1'b1; cmd_arg0 <= '0;
            st <= S_SET;
          end
        end
        S_SET: if (cmd_ack) begin
          if (!ok_rsp) begin done <= 1'b1; err <= 1'b1; st <= S_IDLE; end
          else begin mb_rd <= 1'b1; mb_addr <= FREQ_OFS; st <= S_FRQ; end
        end
        S_FRQ: begin
          cmd_req <= 1'b1; cmd_code <= OP_SET_STATE; cmd_send <= 1'b1;
          if (idx == LAST) begin
            cmd_arg0 <= saved; st <= S_RESTORE;
          end else begin
            idx <= idx + 1'b1; cmd_arg0 <= DW'(idx + 1'b1); st <= S_SET;
          end
        end
        S_RESTORE: if (cmd_ack) begin
          if (!ok_rsp) begin done <= 1'b1; err <= 1'b1; st <= S_IDLE; end
          else begin
            cmd_req <= 1'b1; cmd_code <= OP_ENABLE; cmd_send <= 1'b0; cmd_arg0 <= '0;
            st <= S_ENABLE;
          end
        end
        S_ENABLE: if (cmd_ack) begin
          if (!ok_rsp) begin done <= 1'b1; err <= 1'b1; st <= S_IDLE; end
          else begin
            cmd_req <= 1'b1; cmd_code <= OP_GET_STATE; cmd_send <= 1'b0; cmd_arg0 <= '0;
            st <= S_GET1;
          end
        end
        S_GET1: if (cmd_ack) begin
          done <= 1'b1; st <= S_IDLE;
          if (commit) begin
            tbl_valid <= 1'b1; cur_state <= cmd_rarg0[IW-1:0]; cur_khz <= rd_khz;
          end else err <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pstate_discovery_chk.sv
module pstate_discovery_chk #(
  parameter int NUM_STATES = 5,
  parameter int DW = 32,
  localparam int IW = (NUM_STATES > 1) ? $clog2(NUM_STATES) : 1
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmd_req,
  input logic [7:0]               cmd_code,
  input logic                     cmd_send,
  input logic [DW-1:0]            cmd_arg0,
  input logic                     cmd_ack,
  input logic                     mb_rd,
  input logic [NUM_STATES*DW-1:0] tbl_khz,
  input logic                     tbl_valid,
  input logic [IW-1:0]            cur_state,
  input logic                     fw_ok,
  input logic                     done,
  input logic                     err
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_req && !cmd_ack |=> cmd_req);
  p_req_stable_r11: assert property (@(posedge clk) disable iff (rst)
    cmd_req && !cmd_ack |=> $stable(cmd_code) && $stable(cmd_send) && $stable(cmd_arg0));
  p_rd_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    mb_rd |=> !mb_rd);
  p_busy_invalid_r10: assert property (@(posedge clk) disable iff (rst)
    cmd_req |-> !tbl_valid);
  p_table_held_r10: assert property (@(posedge clk) disable iff (rst)
    !tbl_valid |=> tbl_valid || $stable(tbl_khz));
  p_err_done_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
  p_valid_fw_r2: assert property (@(posedge clk) disable iff (rst)
    tbl_valid |-> fw_ok && done && !err);
  p_state_range_r9: assert property (@(posedge clk) disable iff (rst)
    tbl_valid |-> cur_state <= IW'(NUM_STATES - 1));
endmodule

bind pstate_discovery pstate_discovery_chk #(.NUM_STATES(NUM_STATES), .DW(DW)) u_chk (.*);

// File: tb/pstate_discovery_bench.sv
module pstate_discovery_bench;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic cmd_req, cmd_send, cmd_ack = 1'b0, mb_rd;
  logic [7:0] cmd_code, cmd_status = 8'h00, mb_addr;
  logic [31:0] cmd_arg0, cmd_rarg0 = '0, mb_rdata = '0, cur_khz;
  logic [159:0] tbl_khz;
  logic tbl_valid, fw_ok, done, err;
  logic [2:0] cur_state;

  always #5 clk = ~clk;

  pstate_discovery u_pstate_discovery (.*);

  int total = 0, bad = 0, cyc = 0;
  // model state
  logic [31:0] magic = 32'hA11600D1;
  logic [31:0] freq [5];
  int model_ps = 0;
  logic [7:0] map_st = 8'hF0;
  int fail_idx = -1;
  logic [7:0] fail_st = 8'hFF;
  bit force_rb = 0;
  // logs
  logic [7:0] lc [32];
  logic [31:0] la [32];
  logic ls [32];
  logic [7:0] lr [32];
  int ncmd = 0, nrd = 0, ngets = 0, mism = 0;
  bit busy = 0;
  int cnt = 0;
  logic [7:0] code0;
  logic [31:0] arg0_0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (mb_rd) begin
      mb_rdata = (mb_addr == 8'h34) ? magic : (mb_addr == 8'h50) ? freq[model_ps] : 32'h0;
      if (nrd < 32) lr[nrd] = mb_addr;
      nrd++;
    end
    if (cmd_ack) cmd_ack = 1'b0;
    else if (cmd_req && !busy) begin
      busy = 1; cnt = 1 + int'($urandom % 4); code0 = cmd_code; arg0_0 = cmd_arg0;
    end else if (busy) begin
      cnt--;
      if (cnt == 0) begin
        busy = 0;
        if (cmd_code != code0 || cmd_arg0 != arg0_0) mism++;
        if (ncmd < 32) begin lc[ncmd] = cmd_code; la[ncmd] = cmd_arg0; ls[ncmd] = cmd_send; end
        cmd_status = (cmd_code == 8'h30) ? map_st : 8'hF0;
        if (ncmd == fail_idx) cmd_status = fail_st;
        cmd_rarg0 = 32'h0;
        if (cmd_code == 8'h40) begin
          cmd_rarg0 = 32'(model_ps);
          if (force_rb && ngets == 1) cmd_rarg0 = 32'd7;
          ngets++;
        end
        if (cmd_code == 8'h41 && cmd_status == 8'hF0) model_ps = int'(cmd_arg0);
        ncmd++;
        cmd_ack = 1'b1;
      end
    end
  end

  function automatic logic [31:0] exp_khz(logic [31:0] x);
    longint p = longint'(x) * 1000;
    return (p > 64'hFFFFFFFF) ? 32'hFFFFFFFF : p[31:0];
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic run();
    ncmd = 0; nrd = 0; ngets = 0; mism = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int w = 0; w < 3000 && !done; w++) @(negedge clk);
    chk(done, "run completes", done, 1);
  endtask

  task automatic check_ok(int init_ps);
    chk(!err && tbl_valid && fw_ok, "R7 success flags", {err, tbl_valid, fw_ok}, 3'b011);
    for (int i = 0; i < 5; i++)
      chk(tbl_khz[i*32 +: 32] == exp_khz(freq[i]), "R5 entry kHz", tbl_khz[i*32 +: 32], exp_khz(freq[i]));
    chk(ncmd == 10, "R4 command count", ncmd, 10);
    chk(lc[0] == 8'h30 && lc[1] == 8'h40 && !ls[1], "R3 map then state fetch", {lc[0], lc[1]}, 16'h3040);
    for (int i = 0; i < 5; i++)
      chk(lc[2+i] == 8'h41 && ls[2+i] && la[2+i] == 32'(i), "R4 scan order", la[2+i], i);
    chk(nrd == 6 && lr[0] == 8'h34 && lr[5] == 8'h50, "R4 mailbox reads", nrd, 6);
    chk(lc[7] == 8'h41 && la[7] == 32'(init_ps), "R6 restore", la[7], init_ps);
    chk(lc[8] == 8'h11 && lc[9] == 8'h40, "R7 enable then fetch", {lc[8], lc[9]}, 16'h1140);
    chk(cur_state == 3'(init_ps), "R7 cur_state", cur_state, init_ps);
    chk(cur_khz == exp_khz(freq[init_ps]), "R7 cur_khz", cur_khz, exp_khz(freq[init_ps]));
    chk(mism == 0, "R11 request held stable", mism, 0);
  endtask

  initial begin
    logic [159:0] old;
    int ps;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 5; i++) freq[i] = 32'(100 * (i + 1));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!tbl_valid && !done && !err && !fw_ok && !cmd_req && !mb_rd && cur_khz == 0 && tbl_khz == 0,
        "R1 reset state", {tbl_valid, done, err, fw_ok, cmd_req, mb_rd}, 0);

    // directed success, start state 2
    model_ps = 2; run(); check_ok(2);

    // saturation boundary
    freq[0] = 32'd4294967; freq[1] = 32'd4294968; freq[2] = 32'hFFFFFFFF; freq[3] = 0; freq[4] = 1;
    model_ps = 4; run(); check_ok(4);

    // R10: table held and invalid during a run
    old = tbl_khz;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (6) @(negedge clk);
    chk(!tbl_valid && tbl_khz == old, "R10 held invalid while busy", tbl_valid, 0);
    for (int w = 0; w < 3000 && !done; w++) @(negedge clk);

    // R2: wrong magic
    magic = 32'h12345678; run();
    chk(err && !fw_ok && !tbl_valid && ncmd == 1, "R2 bad magic", ncmd, 1);
    magic = 32'hA11600D1;

    // R2: map returns not supported / invalid
    map_st = 8'hF2; run();
    chk(err && !fw_ok && ncmd == 1, "R2 map not supported", {err, fw_ok}, 2'b10);
    map_st = 8'hF1; run();
    chk(err && !fw_ok, "R2 map invalid", {err, fw_ok}, 2'b10);
    // other map error still counts as present
    map_st = 8'hF4; model_ps = 1; run(); check_ok(1);
    map_st = 8'hF0;

    // R8: failure at set-state of entry 3 keeps old table
    old = tbl_khz; freq[3] = 32'd777;
    fail_idx = 5; fail_st = 8'hFF; model_ps = 0; run();
    chk(err && !tbl_valid && tbl_khz == old && ncmd == 6, "R8 abort keeps table", ncmd, 6);
    fail_idx = 8; fail_st = 8'hF3; run();
    chk(err && !tbl_valid && tbl_khz == old, "R8 enable failure", err, 1);
    fail_idx = -1;

    // R9: final readback out of range
    force_rb = 1; run();
    chk(err && !tbl_valid && fw_ok, "R9 readback above 4", {err, tbl_valid}, 2'b10);
    force_rb = 0;

    // random runs
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < 5; i++)
        freq[i] = ($urandom % 4 == 0) ? $urandom : ($urandom % 5000000);
      ps = int'($urandom % 5); model_ps = ps;
      run(); check_ok(ps);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule